// File: doc/BRIEF.md
# Saturating Rounding Vector Shifter

This block shifts every element of a packed 64-bit integer vector by its own signed amount in a single pass. A positive amount moves the element left and a negative amount moves it right. Elements can be 8, 16, 32 or 64 bits wide. Three interpretation modes are supported: the element is signed; the element is unsigned; or a signed element produces an unsigned result. Right shifts can optionally round half up. Left shifts can optionally saturate on overflow.

One request is accepted per cycle under a valid strobe. The result appears one clock later with its own valid signal. A sticky flag records that at least one lane has saturated since the last clear. It is intended as the shift unit of a vector integer pipeline, where the flag feeds a cumulative status bit.

Top module: `vec_sat_shift`

## Requirements
- R1: `elem_sel` picks the element width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Lane i occupies bits [i*W +: W] of both words. A lane's shift amount is the two's-complement value in bits [i*W +: 8] of `amt_in`, and the remaining bits of that lane of `amt_in` are ignored.
- R2: A negative amount -n without rounding shifts right by n. The shift is arithmetic in signed mode (`mode_sel` = 0) and logical in the unsigned modes (`mode_sel` = 1, 2 or 3). In signed mode with n >= W, the result is all ones for a negative element and zero otherwise.
- R3: A rounded right shift by n returns floor((x + 2^(n-1)) / 2^n). In signed mode with n >= W and rounding on, the result is 0.
- R4: In the unsigned modes the result is 0 when n >= W+1 with rounding on, or when n >= W with rounding off. For n = W with rounding on, the result equals the element's top bit.
- R5: A left shift by k, with 0 <= k < W, returns the low W bits of x*2^k when saturation is off or the exact product fits the element's range. The signed range is [-2^(W-1), 2^(W-1)-1] and the unsigned range is [0, 2^W-1].
- R6: When saturation is on and the exact left-shifted value is outside the range, the lane saturates. A signed lane gives the most positive value for a non-negative element and the most negative value for a negative element. An unsigned lane gives all ones.
- R7: A left shift by k >= W gives 0 when saturation is off or the element is 0. Otherwise the lane saturates as in R6.
- R8: In mode 2 with saturation on, a negative element gives 0 and counts as saturated. Every other element in mode 2 follows the unsigned rules. Mode 3 behaves exactly like mode 1.
- R9: `sat_flag` is set in the cycle after an accepted request in which any lane saturated. It stays set until `clr_sat`, and `clr_sat` wins over a set in the same cycle.
- R10: `data_out` and `out_valid` present a request one cycle after `in_valid`. `data_out` holds its value while `in_valid` is low, and `out_valid` is high only in the cycle after `in_valid`.
- R11: While `rst_n` is low at a clock edge, `data_out`, `out_valid` and `sat_flag` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| elem_sel | input | 2 | Element width code |
| mode_sel | input | 2 | Signedness mode code |
| round_en | input | 1 | Round right shifts half up |
| sat_en | input | 1 | Saturate on overflow |
| data_in | input | 64 | Packed source elements |
| amt_in | input | 64 | Packed per-lane shift amounts |
| clr_sat | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| data_out | output | 64 | Packed shifted elements |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench sweeps the amounts -W-1, -W, -2, -1, 0, 1, W-1 and W against zero, one, the extreme signed values, all ones and a small pattern. It covers every width, mode, rounding and saturation setting, and rotates the values across lanes so that neighbouring lanes differ. A design that clamped large right shifts wrongly would return the sign fill instead of 0 under signed rounding, or would zero an unsigned rounded shift by exactly W. A design with an off-by-one overflow test would either miss the saturation of the minimum value shifted by W-1 or wrongly saturate a value that fits. Further checks show that a non-saturating request leaves the flag set, that a clear beats a same-cycle set, and that garbage in the upper bits of each amount lane is ignored.

// File: rtl/vss_pkg.sv
`timescale 1ns/1ps
// Shared types for the vector shifter.
// Assumes a 64-bit datapath and 2-bit width and mode codes.
package vss_pkg;
    localparam int DATA_W = 64;
    localparam int AMT_W  = 8;
    localparam int NUM_WIDTHS = 4;

    typedef enum logic [1:0] {
        MODE_SIGNED = 2'd0,
        MODE_UNSIGN = 2'd1,
        MODE_S2U    = 2'd2,
        MODE_UALT   = 2'd3
    } mode_t;
endpackage

// File: rtl/vss_lane.sv
`timescale 1ns/1ps
// One lane of the shifter: a purely combinational shift with rounding
// and saturation for a single element of width W.
// Assumes the amount is an 8-bit two's-complement value and W <= 64.
module vss_lane
    import vss_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      src,
    input  logic [AMT_W-1:0]  amt,
    input  mode_t             mode,
    input  logic              rnd,
    input  logic              sat,
    output logic [W-1:0]      res,
    output logic              sat_hit
);
    localparam logic [8:0] W9 = 9'(W);

    logic              is_s;
    logic              sneg;
    logic [8:0]        rmag;
    logic [6:0]        lamt;
    logic [W-1:0]      sat_val;
    logic [2*W-1:0]    wide;
    logic [W:0]        top_bits;
    logic              ovf;
    logic signed [W-1:0] t_s;
    logic [W-1:0]      t_u;

    // Decode the lane's sign, shift magnitudes and saturation value
    always_comb begin
        is_s = (mode == MODE_SIGNED);
        sneg = src[W-1];
        rmag = 9'h100 - {1'b0, amt};
        lamt = amt[6:0];
        if (is_s)
            sat_val = sneg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            sat_val = {W{1'b1}};
    end

    // Left-shift overflow detection on a double-width product
    always_comb begin
        wide     = {{W{is_s & sneg}}, src} << lamt;
        top_bits = wide[2*W-1:W-1];
        if (is_s)
            ovf = ~((&top_bits) | ~(|top_bits));
        else
            ovf = |top_bits[W:1];
    end

    // Select the lane result from the shift direction and corner rules
    always_comb begin
        res     = '0;
        sat_hit = 1'b0;
        t_s     = '0;
        t_u     = '0;
        if (mode == MODE_S2U && sat && sneg) begin
            sat_hit = 1'b1;
        end else if (amt[AMT_W-1]) begin
            if (is_s) begin
                if (rmag >= W9) begin
                    res = rnd ? '0 : {W{sneg}};
                end else if (rnd) begin
                    t_s = $signed(src) >>> (rmag - 9'd1);
                    res = W'(t_s >>> 1) + {{(W-1){1'b0}}, t_s[0]};
                end else begin
                    res = W'($signed(src) >>> rmag);
                end
            end else begin
                if (rmag >= W9 + {8'd0, rnd}) begin
                    res = '0;
                end else if (rnd) begin
                    t_u = src >> (rmag - 9'd1);
                    res = (t_u >> 1) + {{(W-1){1'b0}}, t_u[0]};
                end else begin
                    res = src >> rmag;
                end
            end
        end else if ({2'b00, lamt} >= W9) begin
            if (sat && (src != '0)) begin
                sat_hit = 1'b1;
                res     = sat_val;
            end
        end else if (sat && ovf) begin
            sat_hit = 1'b1;
            res     = sat_val;
        end else begin
            res = wide[W-1:0];
        end
    end

    // A saturated lane only ever shows a saturation value or zero
    always_comb begin
        if (sat_hit) begin
            p_satval_r6: assert (res == sat_val || res == '0)
                else $error("lane saturated to an unexpected value");
        end
    end
endmodule

// File: rtl/vss_lane_array.sv
`timescale 1ns/1ps
// All lanes for one element width across the 64-bit datapath.
// Assumes W divides DATA_W and W >= AMT_W.
module vss_lane_array
    import vss_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] amt_in,
    input  mode_t             mode,
    input  logic              rnd,
    input  logic              sat,
    output logic [DATA_W-1:0] res,
    output logic              sat_any
);
    localparam int NL = DATA_W / W;

    logic [NL-1:0] hits;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        vss_lane #(.W(W)) u_lane (
            .src     (data_in[i*W +: W]),
            .amt     (amt_in[i*W +: AMT_W]),
            .mode    (mode),
            .rnd     (rnd),
            .sat     (sat),
            .res     (res[i*W +: W]),
            .sat_hit (hits[i])
        );
    end

    // Any lane saturating raises the array's saturation indication
    always_comb sat_any = |hits;
endmodule

// File: rtl/vec_sat_shift.sv
`timescale 1ns/1ps
// Registered top of the lane-parallel saturating rounding shifter.
// Builds one lane array per element width, selects by elem_sel and
// registers the result. Keeps a sticky saturation flag with clear priority.
// Assumes synchronous active-low reset.
module vec_sat_shift
    import vss_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  elem_sel,
    input  logic [1:0]  mode_sel,
    input  logic        round_en,
    input  logic        sat_en,
    input  logic [63:0] data_in,
    input  logic [63:0] amt_in,
    input  logic        clr_sat,
    output logic        out_valid,
    output logic [63:0] data_out,
    output logic        sat_flag
);
    logic [DATA_W-1:0]     res_w [NUM_WIDTHS];
    logic [NUM_WIDTHS-1:0] sat_w;
    logic [DATA_W-1:0]     res_sel;
    logic                  sat_sel;
    mode_t                 mode;

    // Cast the raw mode code to the shared enum
    always_comb mode = mode_t'(mode_sel);

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        vss_lane_array #(.W(8 << g)) u_arr (
            .data_in (data_in),
            .amt_in  (amt_in),
            .mode    (mode),
            .rnd     (round_en),
            .sat     (sat_en),
            .res     (res_w[g]),
            .sat_any (sat_w[g])
        );
    end

    // Pick the array that matches the requested element width
    always_comb begin
        res_sel = res_w[elem_sel];
        sat_sel = sat_w[elem_sel];
    end

    // Register the result and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                data_out <= res_sel;
        end
    end

    // Sticky saturation flag, clear takes priority over set
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_flag <= 1'b0;
        else if (clr_sat)
            sat_flag <= 1'b0;
        else if (in_valid && sat_sel)
            sat_flag <= 1'b1;
    end

    p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(data_out));
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sat |=> !sat_flag);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr_sat) |=> sat_flag);
    p_set_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag && !(in_valid && sat_sel)) |=> !sat_flag);
endmodule

// File: tb/sim_vec_sat_shift.sv
`timescale 1ns/1ps
// Directed bench for vec_sat_shift with an exact-arithmetic reference.
module sim_vec_sat_shift;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  elem_sel;
    logic [1:0]  mode_sel;
    logic        round_en;
    logic        sat_en;
    logic [63:0] data_in;
    logic [63:0] amt_in;
    logic        clr_sat;
    logic        out_valid;
    logic [63:0] data_out;
    logic        sat_flag;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_sat_shift u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_sel(elem_sel),
        .mode_sel(mode_sel), .round_en(round_en), .sat_en(sat_en),
        .data_in(data_in), .amt_in(amt_in), .clr_sat(clr_sat),
        .out_valid(out_valid), .data_out(data_out), .sat_flag(sat_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Exact-arithmetic model of one lane
    function automatic void ref_lane(input int w, input int mode, input bit rnd, input bit sat,
                                     input logic [63:0] raw, input int a,
                                     output logic [63:0] res, output bit s, output string tag);
        logic signed [199:0] one, v, r, lo, hi, mask;
        bit sgn, neg;
        int n;
        one  = 1;
        mask = (one <<< w) - one;
        sgn  = (mode == 0);
        neg  = raw[w-1];
        s    = 1'b0;
        if (mode == 2 && sat && neg) begin
            res = '0; s = 1'b1; tag = "R8"; return;
        end
        v = $signed({136'd0, raw}) & mask;
        if (sgn && neg) v = v - (one <<< w);
        lo = sgn ? -(one <<< (w-1)) : 0;
        hi = sgn ? (one <<< (w-1)) - one : mask;
        if (a < 0) begin
            n = -a;
            if (rnd) r = (v + (one <<< (n-1))) >>> n;
            else     r = v >>> n;
            if (sgn && n >= w) tag = rnd ? "R3" : "R2";
            else if (!sgn && n >= w) tag = "R4";
            else tag = rnd ? "R3" : "R2";
        end else begin
            r = v <<< a;
            tag = (a >= w) ? "R7" : "R5";
            if ((r < lo || r > hi) && sat) begin
                s = 1'b1;
                r = (sgn && v < 0) ? lo : hi;
                if (a < w) tag = "R6";
            end
        end
        res = 64'(r & mask);
    endfunction

    // Apply one request after a clear, then check result and flag
    task automatic run_vec(input int w, input int mode, input bit rnd, input bit sat,
                           input logic [63:0] d, input logic [63:0] am,
                           input logic [63:0] exp_d, input bit exp_s, input string tag);
        @(negedge clk);
        clr_sat = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        clr_sat = 1'b0; in_valid = 1'b1;
        elem_sel = 2'(w == 8 ? 0 : w == 16 ? 1 : w == 32 ? 2 : 3);
        mode_sel = 2'(mode); round_en = rnd; sat_en = sat;
        data_in = d; amt_in = am;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 data"}, data_out, exp_d);
        check({tag, " R9 flag"}, {63'd0, sat_flag}, {63'd0, exp_s});
        check("R10 out_valid", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; clr_sat = 1'b0;
        elem_sel = '0; mode_sel = '0; round_en = 1'b0; sat_en = 1'b0;
        data_in = '1; amt_in = '0;
        repeat (3) @(negedge clk);
        check("R11 data_out", data_out, 64'd0);
        check("R11 out_valid", {63'd0, out_valid}, 64'd0);
        check("R11 sat_flag", {63'd0, sat_flag}, 64'd0);
        rst_n = 1'b1;
    endtask

    // Sweep widths, modes, rounding, saturation, amounts and extremes
    task automatic t_sweep();
        logic [63:0] vals [6];
        int          amts [8];
        logic [63:0] d, am, ed, lr, ones;
        bit          es, ls;
        string       tg, first;
        for (int wi = 0; wi < 4; wi++) begin
            int w = 8 << wi;
            ones = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            vals[0] = 64'd0; vals[1] = 64'd1;
            vals[2] = (64'd1 << (w-1)) - 64'd1;
            vals[3] = 64'd1 << (w-1);
            vals[4] = ones; vals[5] = 64'd5;
            amts[0] = -w-1; amts[1] = -w; amts[2] = -2; amts[3] = -1;
            amts[4] = 0; amts[5] = 1; amts[6] = w-1; amts[7] = w;
            for (int md = 0; md < 4; md++)
                for (int rs = 0; rs < 4; rs++)
                    for (int vi = 0; vi < 6; vi++)
                        for (int ai = 0; ai < 8; ai++) begin
                            d = '0; am = {8{8'hA5}}; ed = '0; es = 1'b0; first = "";
                            for (int ln = 0; ln < 64 / w; ln++) begin
                                logic [63:0] v = vals[(vi + ln) % 6];
                                int          a = amts[(ai + ln) % 8];
                                d[ln*w +: 8] = v[7:0];
                                if (w > 8) for (int b = 8; b < w; b++) d[ln*w + b] = v[b];
                                am[ln*w +: 8] = 8'(a);
                                ref_lane(w, md, rs[0], rs[1], v, a, lr, ls, tg);
                                for (int b = 0; b < w; b++) ed[ln*w + b] = lr[b];
                                es = es | ls;
                                if (first == "") first = tg;
                            end
                            run_vec(w, md, rs[0], rs[1], d, am, ed, es, first);
                        end
        end
    endtask

    // Sticky flag and clear priority
    task automatic t_sticky();
        run_vec(8, 1, 1'b0, 1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001,
                64'h0000_0000_0000_00FF, 1'b1, "R6 set");
        @(negedge clk);
        in_valid = 1'b1; sat_en = 1'b0; data_in = 64'h11; amt_in = 64'h0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; clr_sat = 1'b0;
        check("R9 flag sticky", {63'd0, sat_flag}, 64'd1);
        check("R9 no-sat data", data_out, 64'h11);
        in_valid = 1'b1; clr_sat = 1'b1; sat_en = 1'b1;
        elem_sel = 2'd0; mode_sel = 2'd1; data_in = 64'hFF; amt_in = 64'h1;
        @(negedge clk);
        in_valid = 1'b0; clr_sat = 1'b0;
        check("R9 clear beats set", {63'd0, sat_flag}, 64'd0);
    endtask

    // Output holds while no request is presented
    task automatic t_hold();
        logic [63:0] prev;
        @(negedge clk);
        prev = data_out;
        in_valid = 1'b0; data_in = 64'h1234_5678_9ABC_DEF0; amt_in = 64'h0;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold data", data_out, prev);
        check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_sticky();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule